// File: doc/BRIEF.md
# Zero-Run Detector with Halt

This block watches a serial bit stream, one bit per clock, and raises a flag in the very cycle that a third zero in a row is on its input. The flag repeats on every further zero, so long runs of zeros are flagged continuously. A competing pattern, four ones in a row, locks the detector into a stopped condition. There it raises a halt indication, stops looking at the stream and waits for the synchronous active-low reset.

Alongside the detector, a two-bit registered tally counts the zeros accepted since reset was released, modulo four. Zeros that arrive while the machine is stopped, or while reset is held low, are not counted. The controller is a seven-state machine held in three flip-flops. Reset acts only at clock edges and does not mask the zero flag itself.

Top module: `zero_run_halt`

## Requirements
- R1: When reset_n is low at a rising clock edge, the machine returns to its start condition on that edge. Afterwards halt is 0, zcount is 0 and any zero or one run seen before the edge is forgotten.
- R2: zeros is 1 combinationally, in the same cycle, when x is 0 and the two previous bits sampled since the last reset edge were also 0, with no four-ones halt in between; otherwise zeros is 0.
- R3: Runs may overlap: while the zero run continues, every further 0 on x keeps zeros at 1.
- R4: reset_n does not gate zeros: with two zeros already sampled, x=0 raises zeros even during a cycle in which reset_n is low.
- R5: Four consecutive 1s sampled with reset_n high set halt to 1 in the cycle after the edge that sampled the fourth 1. A 0 anywhere in the run restarts the ones count.
- R6: While halt is 1, x is ignored: halt stays 1, zeros stays 0 and zcount does not change until a reset edge.
- R7: zcount increments by one on each rising edge where reset_n is 1, halt is 0 and x is 0, and wraps from 3 to 0.
- R8: zcount clears to 0 on an edge where reset_n is 0. Zeros present on x during reset are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; x is sampled on each edge |
| reset_n | input | 1 | Synchronous reset, active low |
| x | input | 1 | Serial data bit |
| zeros | output | 1 | Combinational flag: third or later consecutive 0 present on x |
| halt | output | 1 | Registered: four consecutive 1s were seen; detector stopped |
| zcount | output | 2 | Registered count of accepted zeros, modulo 4 |

## Verification
The bench drives x=0 with reset_n low while two zeros are already pending. A design that gated the flag with reset would stay quiet here, and one that counted that zero would show zcount 1 afterwards. It runs three ones followed by a zero, then four ones, to catch a ones counter that ignores the break or halts one cycle early or late. While halted it feeds long zero runs, which expose a design that keeps flagging or counting in the stopped state. Five counted zeros check the wrap from 3 to 0. Long random streams with sparse resets then mix all of these orderings.

// File: rtl/zrh_pkg.sv
package zrh_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_Z1   = 3'd1,
    S_Z2   = 3'd2,
    S_O1   = 3'd3,
    S_O2   = 3'd4,
    S_O3   = 3'd5,
    S_STOP = 3'd6
  } zrh_state_t;

  // Next state for a sampled bit, ignoring reset.
  function automatic zrh_state_t step_state(input zrh_state_t s, input logic xb);
    zrh_state_t n;
    case (s)
      S_IDLE:  n = xb ? S_O1 : S_Z1;
      S_Z1:    n = xb ? S_O1 : S_Z2;
      S_Z2:    n = xb ? S_O1 : S_Z2;
      S_O1:    n = xb ? S_O2 : S_Z1;
      S_O2:    n = xb ? S_O3 : S_Z1;
      S_O3:    n = xb ? S_STOP : S_Z1;
      S_STOP:  n = S_STOP;
      default: n = S_IDLE;
    endcase
    return n;
  endfunction

  // Mealy flag: a zero arriving with two zeros already behind it.
  function automatic logic zero_hit(input zrh_state_t s, input logic xb);
    return (s == S_Z2) && !xb;
  endfunction

  function automatic logic is_stopped(input zrh_state_t s);
    return s == S_STOP;
  endfunction

endpackage

// File: rtl/zrh_ctrl.sv
module zrh_ctrl
  import zrh_pkg::*;
(
  input  logic       clk,
  input  logic       reset_n,
  input  logic       x,
  output zrh_state_t state
);
  zrh_state_t state_nx;

  always_comb begin
    if (!reset_n) state_nx = S_IDLE;
    else          state_nx = step_state(state, x);
  end

  always_ff @(posedge clk) begin
    state <= state_nx;
  end
endmodule

// File: rtl/zrh_counter.sv
module zrh_counter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         reset_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = 1;

  function automatic logic [W-1:0] bump(input logic [W-1:0] c);
    return c + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!reset_n)  count <= '0;
    else if (inc)  count <= bump(count);
  end
endmodule

// File: rtl/zrh_decode.sv
module zrh_decode
  import zrh_pkg::*;
(
  input  zrh_state_t state,
  input  logic       x,
  input  logic       reset_n,
  output logic       zeros,
  output logic       halt,
  output logic       cnt_en
);
  always_comb begin
    zeros  = zero_hit(state, x);
    halt   = is_stopped(state);
    cnt_en = reset_n && !is_stopped(state) && !x;
  end
endmodule

// File: rtl/zero_run_halt.sv
module zero_run_halt
  import zrh_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             reset_n,
  input  logic             x,
  output logic             zeros,
  output logic             halt,
  output logic [CNT_W-1:0] zcount
);
  zrh_state_t state;
  logic       cnt_en;

  zrh_ctrl u_ctrl (
    .clk     (clk),
    .reset_n (reset_n),
    .x       (x),
    .state   (state)
  );

  zrh_decode u_dec (
    .state   (state),
    .x       (x),
    .reset_n (reset_n),
    .zeros   (zeros),
    .halt    (halt),
    .cnt_en  (cnt_en)
  );

  zrh_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .reset_n (reset_n),
    .inc     (cnt_en),
    .count   (zcount)
  );
endmodule

// File: rtl/zrh_checker.sv
module zrh_checker #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             reset_n,
  input logic             x,
  input logic             zeros,
  input logic             halt,
  input logic [CNT_W-1:0] zcount
);
  localparam logic [CNT_W-1:0] ONE = 1;

  // Independent run trackers built from the ports only.
  logic [1:0] zrun;
  logic [2:0] orun;

  always_ff @(posedge clk) begin
    if (!reset_n) begin
      zrun <= 2'd0;
      orun <= 3'd0;
    end else if (orun != 3'd4) begin
      if (x) begin
        zrun <= 2'd0;
        orun <= orun + 3'd1;
      end else begin
        zrun <= (zrun == 2'd2) ? 2'd2 : zrun + 2'd1;
        orun <= 3'd0;
      end
    end
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    !reset_n |=> (!halt && zcount == '0));

  // R2 R3
  a_r2_zero_flag: assert property (@(posedge clk) disable iff (!reset_n)
    zeros == (orun != 3'd4 && zrun == 2'd2 && !x));

  // R5
  a_r5_halt_after_ones: assert property (@(posedge clk) disable iff (!reset_n)
    halt == (orun == 3'd4));

  // R6
  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!reset_n)
    halt |=> halt);

  a_r6_quiet_halted: assert property (@(posedge clk) disable iff (!reset_n)
    halt |-> !zeros);

  // R7
  a_r7_count_step: assert property (@(posedge clk) disable iff (!reset_n)
    $past(reset_n) |-> zcount == ($past(!halt && !x) ? $past(zcount) + ONE : $past(zcount)));
endmodule

bind zero_run_halt zrh_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .reset_n (reset_n),
  .x       (x),
  .zeros   (zeros),
  .halt    (halt),
  .zcount  (zcount)
);

// File: tb/zero_run_halt_test.sv
`timescale 1ns/1ps
module zero_run_halt_test;
  logic       clk = 1'b0;
  logic       reset_n;
  logic       x;
  logic       zeros;
  logic       halt;
  logic [1:0] zcount;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Bench reference state.
  int m_zr;
  int m_or;
  int m_cnt;

  always #4 clk = ~clk;

  zero_run_halt uut (
    .clk     (clk),
    .reset_n (reset_n),
    .x       (x),
    .zeros   (zeros),
    .halt    (halt),
    .zcount  (zcount)
  );

  function automatic bit exp_zeros(input bit xv);
    return (m_or < 4) && (m_zr >= 2) && !xv;
  endfunction

  function automatic bit exp_halt();
    return m_or >= 4;
  endfunction

  function automatic int exp_count();
    return m_cnt % 4;
  endfunction

  task automatic model_edge(input bit xv, input bit rv);
    if (!rv) begin
      m_zr = 0; m_or = 0; m_cnt = 0;
    end else if (m_or < 4) begin
      if (xv) begin m_or = m_or + 1; m_zr = 0; end
      else    begin m_zr = m_zr + 1; m_or = 0; m_cnt = m_cnt + 1; end
    end
  endtask

  task automatic check1(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit xv, input bit rv, input string tag);
    @(negedge clk);
    x = xv;
    reset_n = rv;
    #1;
    check1(tag, "zeros",  int'(zeros),  int'(exp_zeros(xv)));
    check1(tag, "halt",   int'(halt),   int'(exp_halt()));
    check1(tag, "zcount", int'(zcount), exp_count());
    @(posedge clk);
    model_edge(xv, rv);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    x = 1'b1;
    reset_n = 1'b0;
    repeat (2) @(posedge clk);
    m_zr = 0; m_or = 0; m_cnt = 0;

    // R1: reset state
    step(1'b1, 1'b1, "R1");
    step(1'b0, 1'b1, "R1");           // O1 -> Z1 path, count 1

    // R2 then R3: third zero and overlap
    step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b1, "R3");
    step(1'b0, 1'b1, "R3");
    step(1'b1, 1'b1, "R3");
    step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b1, "R2");
    step(1'b1, 1'b1, "R2");

    // R4: zero flag not gated by reset; R8: that zero not counted
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b0, "R4");
    step(1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, "R1");           // run forgotten after reset
    step(1'b1, 1'b1, "R1");

    // R5: broken ones run, then four ones
    step(1'b1, 1'b1, "R5");
    step(1'b1, 1'b1, "R5");
    step(1'b0, 1'b1, "R5");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R5");

    // R6: halted stream ignored
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, "R6");
    step(1'b1, 1'b1, "R6");
    step(1'b0, 1'b0, "R6");

    // R7: wrap after five counted zeros
    step(1'b1, 1'b1, "R7");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R7");
    step(1'b1, 1'b1, "R7");
    step(1'b0, 1'b0, "R8");
    step(1'b1, 1'b1, "R8");

    // Random mix
    void'($urandom(32'd5150));
    for (int i = 0; i < 4000; i++) begin
      bit xv;
      bit rv;
      xv = ($urandom % 2) == 1;
      rv = ($urandom % 48) != 0;
      step(xv, rv, "R2_R5_R7_random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule